// File: doc/BRIEF.md
# Address Translation Unit with TLB and Page-Table Fallback

This block turns a 32-bit virtual address into a physical address. The low 12 bits select a byte inside a 4 KB page and pass through untouched. The upper 20 bits form the virtual page number, which is first looked up in a four-entry, fully associative translation buffer. Each buffer entry holds a valid flag, the page-number tag, the physical page number and an age rank.

When the buffer has no entry for the page, the unit reads a 16-entry flat page table. The table is indexed by the low four bits of the virtual page number. If that table entry is valid, its physical page is loaded into the buffer. If it is invalid, the access is a page fault: the unit hands out the next unused physical page number (13 first, then counting up), marks the table entry valid with that page, and then loads the buffer as it would on a miss.

Requests use a valid/ready handshake. Each result comes back as a single-cycle response pulse carrying the physical address and a two-bit outcome code. Software-visible set-up is limited to a write port that preloads page-table entries.

Top module: `xlt_unit`

## Requirements
- R1: The low 12 bits of `rsp_paddr` equal the low 12 bits of the accepted `req_vaddr`; the upper 20 bits carry the physical page number.
- R2: A request whose page number matches a valid buffer entry is a hit. It returns code 2'b00 with that entry's physical page, and `rsp_valid` is high in the cycle right after the handshake cycle.
- R3: A hit changes no tag, physical page or valid flag in the buffer. A later access to any resident page still hits and returns the same page.
- R4: Ranks run from 1 (oldest) to 4 (newest). An accessed entry becomes rank 4, and only valid entries ranked above its old rank drop by one. A filled entry becomes rank 4, and every other valid entry drops by one.
- R5: When the buffer misses and the page-table entry at index `vpn[3:0]` is valid, the response carries code 2'b01 and that entry's physical page. It arrives two cycles after the handshake cycle.
- R6: A fill replaces the lowest-indexed entry holding rank 1. Invalid entries hold rank 1, so they are filled before any valid entry is evicted.
- R7: When the buffer misses and the page-table entry is invalid, the response carries code 2'b10. It arrives three cycles after the handshake cycle. The assigned physical page is 13 for the first fault after reset and increases by one on each fault.
- R8: A fault writes the assigned page into the page-table entry and sets it valid. A later buffer miss to that entry is then a plain miss that returns the same page.
- R9: `req_ready` is low from the cycle after a non-hit handshake until that request's response cycle. Requests presented in that window are not taken, and responses come back in handshake order.
- R10: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and the buffer holds no valid entry. Every page-table entry is invalid and the page allocator restarts at 13.
- R11: A write on the init port (`pt_init_we` high) stores `pt_init_vld`/`pt_init_ppn` at `pt_init_idx` on the next clock edge. The exception is a cycle in which a fault is recording its own entry; in that cycle the fault write takes precedence.
- R12: The page table uses only `vpn[3:0]` as its index. Page numbers that differ only above bit 3 share one table entry but keep separate buffer entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle pulse: response fields are valid |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_kind | output | 2 | Outcome: 00 hit, 01 miss, 10 page fault |
| pt_init_we | input | 1 | Page-table preload write strobe |
| pt_init_idx | input | 4 | Page-table entry to write |
| pt_init_vld | input | 1 | Valid flag to store |
| pt_init_ppn | input | 20 | Physical page number to store |

## Verification
Each outcome has a fixed delay from the handshake cycle: one cycle for a hit, two for a miss and three for a fault. When the driver sees a request taken, it records the due cycle for that outcome along with the expected code and address, which an independent reference model of the buffer, the table and the allocator supplies. The monitor samples on the falling edge. Each response must arrive in exactly its recorded cycle, and a response with nothing queued counts as an error. Because requests are issued back to back, the busy window is exercised, and a wrong eviction or rank update shows up later as a wrong hit/miss code.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int VA_W       = 32;
    localparam int OFF_W      = 12;
    localparam int VPN_W      = VA_W - OFF_W;
    localparam int PPN_W      = 20;
    localparam int PA_W       = PPN_W + OFF_W;
    localparam int TLB_N      = 4;
    localparam int RANK_W     = $clog2(TLB_N + 1);
    localparam int PT_N       = 16;
    localparam int PT_IDX_W   = $clog2(PT_N);
    localparam int FIRST_FREE = 13;

    typedef enum logic [1:0] {
        XK_HIT   = 2'b00,
        XK_MISS  = 2'b01,
        XK_FAULT = 2'b10
    } xk_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WALK,
        ST_FAULT
    } st_e;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [RANK_W-1:0] rank;
    } tlb_ent_t;

    typedef struct packed {
        logic             vld;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
        return va[VA_W-1:OFF_W];
    endfunction

    function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

    function automatic logic [PT_IDX_W-1:0] pt_index(input logic [VPN_W-1:0] vpn);
        return vpn[PT_IDX_W-1:0];
    endfunction

endpackage

// File: rtl/xlt_tlb_bank.sv
module xlt_tlb_bank
    import xlt_pkg::*;
#(
    parameter int N = TLB_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] look_tag,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             touch,
    input  logic             fill,
    input  logic [VPN_W-1:0] fill_tag,
    input  logic [PPN_W-1:0] fill_ppn
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    tlb_ent_t           ent [N];
    logic [N-1:0]       match;
    logic [N-1:0]       is_low;
    logic [RANK_W-1:0]  hit_rank;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               vic_found;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i]  = ent[i].vld && (ent[i].tag == look_tag);
        assign is_low[i] = (ent[i].rank == RANK_W'(1));
    end

    always_comb begin
        hit      = |match;
        hit_ppn  = '0;
        hit_rank = '0;
        hit_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_ppn  = ent[i].ppn;
                hit_rank = ent[i].rank;
                hit_idx  = IDX_W'(i);
            end
        end
    end

    // lowest index holding the oldest rank is the victim
    always_comb begin
        vic_idx   = '0;
        vic_found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (is_low[i]) begin
                vic_idx   = IDX_W'(i);
                vic_found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                ent[i] <= '{vld: 1'b0, tag: '0, ppn: '0, rank: RANK_W'(1)};
            end
        end else if (touch && hit) begin
            for (int i = 0; i < N; i++) begin
                if (match[i]) begin
                    ent[i].rank <= RANK_W'(N);
                end else if (ent[i].vld && (ent[i].rank > hit_rank)) begin
                    ent[i].rank <= ent[i].rank - RANK_W'(1);
                end
            end
        end else if (fill) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == vic_idx) begin
                    ent[i] <= '{vld: 1'b1, tag: fill_tag, ppn: fill_ppn, rank: RANK_W'(N)};
                end else if (ent[i].vld) begin
                    ent[i].rank <= ent[i].rank - RANK_W'(1);
                end
            end
        end
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    assert_victim_exists_R6: assert property (@(posedge clk) disable iff (rst)
        fill |-> vic_found);

    assert_fill_newest_R6: assert property (@(posedge clk) disable iff (rst)
        (fill && !touch) |=> (ent[$past(vic_idx)].vld && ent[$past(vic_idx)].rank == RANK_W'(N)));

    assert_touch_newest_R4: assert property (@(posedge clk) disable iff (rst)
        (touch && hit) |=> (ent[$past(hit_idx)].rank == RANK_W'(N)));

    for (genvar r = 1; r <= N; r++) begin : g_rank_chk
        logic [N-1:0] holds;
        for (genvar i = 0; i < N; i++) begin : g_h
            assign holds[i] = ent[i].vld && (ent[i].rank == RANK_W'(r));
        end
        assert_rank_unique_R4: assert property (@(posedge clk) disable iff (rst)
            $countones(holds) <= 1);
    end

endmodule

// File: rtl/xlt_page_store.sv
module xlt_page_store
    import xlt_pkg::*;
#(
    parameter int DEPTH = PT_N,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output pte_t          rd_pte,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  pte_t          wr_pte
);
    pte_t tbl [DEPTH];

    assign rd_pte = tbl[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_pte;
        end
    end

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tbl[$past(wr_idx)] == $past(wr_pte)));

endmodule

// File: rtl/xlt_page_alloc.sv
module xlt_page_alloc #(
    parameter int W     = 20,
    parameter int FIRST = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    output logic [W-1:0] next_ppn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            next_ppn <= W'(FIRST);
        end else if (take) begin
            next_ppn <= next_ppn + W'(1);
        end
    end

    assert_alloc_step_R7: assert property (@(posedge clk) disable iff (rst)
        take |=> (next_ppn == $past(next_ppn) + W'(1)));

    assert_alloc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(next_ppn));

endmodule

// File: rtl/xlt_unit.sv
module xlt_unit
    import xlt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VA_W-1:0]     req_vaddr,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic [1:0]          rsp_kind,
    input  logic                pt_init_we,
    input  logic [PT_IDX_W-1:0] pt_init_idx,
    input  logic                pt_init_vld,
    input  logic [PPN_W-1:0]    pt_init_ppn
);
    st_e                 st;
    logic [VA_W-1:0]     hold_va;
    logic                accept;
    logic [VPN_W-1:0]    look_tag;
    logic                tlb_hit;
    logic [PPN_W-1:0]    tlb_ppn;
    logic                tlb_touch;
    logic                tlb_fill;
    logic [PT_IDX_W-1:0] pt_idx;
    pte_t                pt_rd;
    logic                pt_we;
    logic [PT_IDX_W-1:0] pt_widx;
    pte_t                pt_wdata;
    logic                walk_ok;
    logic                walk_fault;
    logic [PPN_W-1:0]    free_ppn;
    xk_e                 kind_q;

    assign req_ready  = (st == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign look_tag   = vpn_of(req_vaddr);
    assign tlb_touch  = accept && tlb_hit;
    assign pt_idx     = pt_index(vpn_of(hold_va));
    assign walk_ok    = (st == ST_WALK) && pt_rd.vld;
    assign walk_fault = (st == ST_WALK) && !pt_rd.vld;
    assign tlb_fill   = walk_ok || (st == ST_FAULT);
    assign rsp_kind   = kind_q;

    always_comb begin
        pt_we    = walk_fault || pt_init_we;
        pt_widx  = walk_fault ? pt_idx : pt_init_idx;
        pt_wdata = walk_fault ? '{vld: 1'b1, ppn: free_ppn}
                              : '{vld: pt_init_vld, ppn: pt_init_ppn};
    end

    xlt_tlb_bank #(.N(TLB_N)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .look_tag (look_tag),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .touch    (tlb_touch),
        .fill     (tlb_fill),
        .fill_tag (vpn_of(hold_va)),
        .fill_ppn (pt_rd.ppn)
    );

    xlt_page_store #(.DEPTH(PT_N)) u_table (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (pt_idx),
        .rd_pte (pt_rd),
        .wr_en  (pt_we),
        .wr_idx (pt_widx),
        .wr_pte (pt_wdata)
    );

    xlt_page_alloc #(.W(PPN_W), .FIRST(FIRST_FREE)) u_alloc (
        .clk      (clk),
        .rst      (rst),
        .take     (walk_fault),
        .next_ppn (free_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            hold_va <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        hold_va <= req_vaddr;
                        if (!tlb_hit) st <= ST_WALK;
                    end
                end
                ST_WALK:  st <= pt_rd.vld ? ST_IDLE : ST_FAULT;
                ST_FAULT: st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            kind_q    <= XK_HIT;
        end else begin
            rsp_valid <= 1'b0;
            if (tlb_touch) begin
                rsp_valid <= 1'b1;
                kind_q    <= XK_HIT;
                rsp_paddr <= {tlb_ppn, off_of(req_vaddr)};
            end else if (walk_ok) begin
                rsp_valid <= 1'b1;
                kind_q    <= XK_MISS;
                rsp_paddr <= {pt_rd.ppn, off_of(hold_va)};
            end else if (st == ST_FAULT) begin
                rsp_valid <= 1'b1;
                kind_q    <= XK_FAULT;
                rsp_paddr <= {pt_rd.ppn, off_of(hold_va)};
            end
        end
    end

    assert_hit_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && tlb_hit) |=> (rsp_valid && rsp_kind == XK_HIT));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && tlb_hit) |=> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    assert_busy_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && !tlb_hit) |=> (!req_ready && !rsp_valid));

    assert_miss_latency_R5: assert property (@(posedge clk) disable iff (rst)
        walk_ok |=> (rsp_valid && rsp_kind == XK_MISS));

    assert_fault_latency_R7: assert property (@(posedge clk) disable iff (rst)
        walk_fault |=> (!rsp_valid ##1 (rsp_valid && rsp_kind == XK_FAULT)));

    assert_fault_records_R8: assert property (@(posedge clk) disable iff (rst)
        walk_fault |=> pt_rd.vld);

endmodule

// File: tb/xlt_unit_test.sv
`timescale 1ns/1ps
module xlt_unit_test;
    import xlt_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_kind;
    logic        pt_init_we;
    logic [3:0]  pt_init_idx;
    logic        pt_init_vld;
    logic [19:0] pt_init_ppn;

    always #2.5 clk = ~clk;

    xlt_unit uut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vaddr   (req_vaddr),
        .rsp_valid   (rsp_valid),
        .rsp_paddr   (rsp_paddr),
        .rsp_kind    (rsp_kind),
        .pt_init_we  (pt_init_we),
        .pt_init_idx (pt_init_idx),
        .pt_init_vld (pt_init_vld),
        .pt_init_ppn (pt_init_ppn)
    );

    int cyc   = 0;
    int total = 0;
    int bad   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          kind;
        logic [31:0] pa;
        int          due;
        string       tag;
    } exp_t;
    exp_t q[$];

    // reference state built from the requirements
    bit          m_v   [4];
    logic [19:0] m_tag [4];
    logic [19:0] m_ppn [4];
    int          m_rk  [4];
    bit          p_v   [16];
    logic [19:0] p_ppn [16];
    int          m_next;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_rk[i] = 1;
        end
        for (int i = 0; i < 16; i++) begin
            p_v[i] = 0; p_ppn[i] = '0;
        end
        m_next = 13;
    endtask

    task automatic model_req(input logic [31:0] va, output int kind, output logic [19:0] ppn);
        logic [19:0] vpn;
        int hitn, old, idx, vic;
        vpn  = va[31:12];
        hitn = -1;
        for (int i = 0; i < 4; i++) if (m_v[i] && m_tag[i] == vpn) hitn = i;
        if (hitn >= 0) begin
            kind = 0;
            ppn  = m_ppn[hitn];
            old  = m_rk[hitn];
            for (int i = 0; i < 4; i++)
                if (i != hitn && m_v[i] && m_rk[i] > old) m_rk[i]--;
            m_rk[hitn] = 4;
        end else begin
            idx = int'(vpn[3:0]);
            if (p_v[idx]) kind = 1;
            else begin
                kind = 2;
                p_v[idx] = 1;
                p_ppn[idx] = m_next[19:0];
                m_next++;
            end
            ppn = p_ppn[idx];
            vic = -1;
            for (int i = 3; i >= 0; i--) if (m_rk[i] == 1) vic = i;
            for (int i = 0; i < 4; i++)
                if (i != vic && m_v[i]) m_rk[i]--;
            m_v[vic] = 1; m_tag[vic] = vpn; m_ppn[vic] = ppn; m_rk[vic] = 4;
        end
    endtask

    // driver: starts and ends on a falling edge
    task automatic send(input logic [31:0] va, input string tag);
        int kind;
        logic [19:0] ppn;
        exp_t e;
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        model_req(va, kind, ppn);
        e.kind = kind;
        e.pa   = {ppn, va[11:0]};
        e.due  = cyc + kind + 1;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pt_write(input int idx, input bit v, input logic [19:0] ppn);
        pt_init_we  = 1'b1;
        pt_init_idx = idx[3:0];
        pt_init_vld = v;
        pt_init_ppn = ppn;
        p_v[idx]    = v;
        p_ppn[idx]  = ppn;
        @(negedge clk);
        pt_init_we  = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (q.size() != 0 && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(q.size() == 0, "R9", "responses outstanding", q.size(), 0);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R9", "response with nothing queued", rsp_paddr, 0);
            end else begin
                exp_t e;
                string ktag;
                e = q.pop_front();
                ktag = (e.kind == 0) ? "R2" : (e.kind == 1) ? "R5" : "R7";
                chk(int'(rsp_kind) == e.kind, e.tag, {ktag, " outcome code"}, rsp_kind, e.kind);
                chk(rsp_paddr[31:12] == e.pa[31:12], e.tag, {ktag, " physical page"},
                    rsp_paddr[31:12], e.pa[31:12]);
                chk(rsp_paddr[11:0] == e.pa[11:0], "R1", "offset passthrough",
                    rsp_paddr[11:0], e.pa[11:0]);
                chk(cyc == e.due, ktag, "response cycle", cyc, e.due);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "R9", "watchdog expired", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0;
        pt_init_we = 1'b0; pt_init_idx = '0; pt_init_vld = 1'b0; pt_init_ppn = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R10", "no response after reset", rsp_valid, 0);

        // page-table preload
        pt_write(0, 1, 20'd5);   pt_write(3, 1, 20'd6);  pt_write(4, 1, 20'd9);
        pt_write(5, 1, 20'd11);  pt_write(7, 1, 20'd4);  pt_write(10, 1, 20'd3);
        pt_write(11, 1, 20'd12);

        // empty buffer after reset: first access misses
        send(32'h0000_0FFF, "R10");
        send(32'h0000_7A28, "R11");
        send(32'h0000_3DAD, "R5");
        send(32'h0000_3A98, "R3");
        send(32'h0000_1C19, "R7");
        send(32'h0000_1000, "R3");
        send(32'h0000_22D0, "R7");
        drain();

        // buffer full: eviction follows the oldest rank
        send(32'h0000_B004, "R6");
        send(32'h0000_3111, "R6");
        send(32'h0000_7222, "R6");
        send(32'h0000_1333, "R6");
        send(32'h0000_2444, "R4");
        send(32'h0000_B555, "R4");
        drain();

        // force page 1 out, then revisit: plain miss with the faulted page
        send(32'h0000_0010, "R8");
        send(32'h0000_3020, "R8");
        send(32'h0000_4030, "R8");
        send(32'h0000_5040, "R8");
        send(32'h0000_1ABC, "R8");
        drain();

        // aliasing through the low four page-number bits
        send(32'h0001_2345, "R12");
        send(32'h0002_0678, "R12");
        send(32'h0002_0679, "R12");
        drain();

        // preload write changes the translation
        pt_write(6, 1, 20'h00077);
        send(32'h0000_6123, "R11");
        drain();

        // fault chain: allocator counts up
        send(32'h0000_8000, "R7");
        send(32'h0000_9FFF, "R7");
        send(32'h0000_C001, "R7");
        send(32'h0000_D800, "R7");
        send(32'h0000_8ABC, "R3");
        drain();

        // back to back mixed traffic, stall while busy
        lcg = 32'h1234_5678;
        for (int k = 0; k < 60; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send({11'd0, lcg[28:24] & 5'h1F, 4'd0, lcg[11:0]}, "R9");
        end
        drain();

        chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule